// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core with Alarm

This block keeps wall-clock time as four counters (seconds, minutes, hours and a plain day count) and steps them on a one-second tick from a prescaler outside the block. Software reads and loads the counters and a matching set of alarm registers through a 16-bit word-addressed register port. The port has no back-pressure: an access with `bus_sel_i` high is taken in the cycle it is presented, and read data follows the address in the same cycle.

Two events are latched in a status register: a per-second update flag and an alarm flag. The alarm flag sets when a tick brings day, hour, minute and second equal to the alarm registers. Software clears flags by writing ones. The single interrupt output is high while any latched flag is also enabled in the enable register. When software loads a time register, the block pulses `presc_clear_o` so that the prescaler restarts its sub-second phase.

Register offsets, in bytes: 0x00 hour/minute, 0x04 seconds, 0x08 alarm hour/minute, 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 interrupt enable, 0x20 day count, 0x24 alarm day. Any other offset reads as zero.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, every counter, alarm register, status flag, enable bit and the control enable read as zero, and `irq_o` and `presc_clear_o` are low.
- R2: Register layout. The hour/minute register and the alarm hour/minute register hold the hour in bits 15:8 and the minute in bits 7:0. Seconds and alarm seconds are in bits 7:0. Day and alarm day are in bits 8:0. Upper bits read as zero, and unmapped offsets read as zero.
- R3: Control bit 7 is the run enable. It reads back as written, and all other control bits read as zero. While it is clear, ticks leave the counters and the status flags unchanged.
- R4: An accepted tick advances seconds. Seconds 59 wraps to 0 and carries into minutes, minutes 59 wraps to 0 and carries into hours, and hours 23 wraps to 0 and carries into the day count. A field loaded above its maximum returns to 0 with a carry on the next tick.
- R5: The day counter is 9 bits wide and wraps from 511 to 0.
- R6: Each accepted tick sets status bit 4. The flag reads as set two cycles after the tick cycle. The counters change one cycle after the tick cycle.
- R7: Status bit 2 sets when an accepted tick makes day, hour, minute and second all equal to the alarm registers. A software write that makes them equal does not set it.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a flag sets in the same cycle as a clear, the set wins.
- R9: `irq_o` is high exactly when (status AND enable) is nonzero. The enable register keeps only bits 2 and 4.
- R10: A write to the seconds, hour/minute or day register is visible on the next cycle. Any such write discards a tick in the same cycle, for the whole counter chain and for the flags. It pulses `presc_clear_o` for the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per second from the prescaler |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, same cycle |
| irq_o | output | 1 | Masked status interrupt |
| presc_clear_o | output | 1 | Restart request for the prescaler phase |

## Verification
A wrong carry or compare state shows up at the register port one cycle after the tick that should have changed it. A missed or spurious alarm or second flag shows up in status and on `irq_o` two cycles after that tick. The bench therefore reads the counters right after each tick, and the flags one cycle later. It pushes every expected value into a scoreboard, so a divergence is reported in the cycle it first becomes visible. The boundary cases are the full day rollover, the wrap of the 9-bit day counter, overrange loads, a write colliding with a tick, and a flag clear colliding with a flag set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // byte offsets decoded by software
  localparam int OFF_HM    = 'h00;
  localparam int OFF_SEC   = 'h04;
  localparam int OFF_AHM   = 'h08;
  localparam int OFF_ASEC  = 'h0C;
  localparam int OFF_CTRL  = 'h10;
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_IEN   = 'h18;
  localparam int OFF_DAY   = 'h20;
  localparam int OFF_ADAY  = 'h24;
  // flag and control bit positions
  localparam int BIT_ALARM  = 2;
  localparam int BIT_SECOND = 4;
  localparam int BIT_RUN    = 7;
  // field limits
  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
endpackage

// File: rtl/rtc_mod_counter.sv
module rtc_mod_counter #(
  parameter int W   = 8,
  parameter int MAX = 59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(MAX);

  logic [W-1:0] cnt_q;

  // overrange values also return to zero with a carry
  assign wrap_o = inc_i && (cnt_q >= LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (inc_i)  cnt_q <= wrap_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FW    = 8,
  parameter int DAY_W = 9
) (
  input  logic [FW-1:0]    sec_i,
  input  logic [FW-1:0]    min_i,
  input  logic [FW-1:0]    hour_i,
  input  logic [DAY_W-1:0] day_i,
  input  logic [FW-1:0]    a_sec_i,
  input  logic [FW-1:0]    a_min_i,
  input  logic [FW-1:0]    a_hour_i,
  input  logic [DAY_W-1:0] a_day_i,
  output logic             hit_o
);
  assign hit_o = (sec_i == a_sec_i) && (min_i == a_min_i) &&
                 (hour_i == a_hour_i) && (day_i == a_day_i);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int DATA_W = 16,
  parameter int A_BIT  = 2,
  parameter int S_BIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_alarm_i,
  input  logic              set_second_i,
  input  logic              stat_wr_i,
  input  logic              ien_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] ien_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'((1 << A_BIT) | (1 << S_BIT));

  logic [DATA_W-1:0] status_q, ien_q, set_vec, clr_vec;

  always_comb begin
    set_vec        = '0;
    set_vec[A_BIT] = set_alarm_i;
    set_vec[S_BIT] = set_second_i;
    clr_vec        = stat_wr_i ? wdata_i : '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      status_q <= '0;
      ien_q    <= '0;
    end else begin
      // a new event outranks a clear in the same cycle
      status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL;
      if (ien_wr_i) ien_q <= wdata_i & IMPL;
    end
  end

  assign status_o = status_q;
  assign ien_o    = ien_q;
  assign irq_o    = |(status_q & ien_q);
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DAY_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              presc_clear_o
);
  localparam int FW       = DATA_W / 2;
  localparam int DAY_LAST = (1 << DAY_W) - 1;

  // ---------------- register decode ----------------
  logic wr_en;
  logic wr_hm, wr_sec, wr_ahm, wr_asec, wr_ctrl, wr_stat, wr_ien, wr_day, wr_aday;
  logic time_wr;

  assign wr_en   = bus_sel_i && bus_wr_i;
  assign wr_hm   = wr_en && (bus_addr_i == ADDR_W'(OFF_HM));
  assign wr_sec  = wr_en && (bus_addr_i == ADDR_W'(OFF_SEC));
  assign wr_ahm  = wr_en && (bus_addr_i == ADDR_W'(OFF_AHM));
  assign wr_asec = wr_en && (bus_addr_i == ADDR_W'(OFF_ASEC));
  assign wr_ctrl = wr_en && (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign wr_stat = wr_en && (bus_addr_i == ADDR_W'(OFF_STAT));
  assign wr_ien  = wr_en && (bus_addr_i == ADDR_W'(OFF_IEN));
  assign wr_day  = wr_en && (bus_addr_i == ADDR_W'(OFF_DAY));
  assign wr_aday = wr_en && (bus_addr_i == ADDR_W'(OFF_ADAY));
  assign time_wr = wr_hm || wr_sec || wr_day;

  // ---------------- control and alarm storage ----------------
  logic             en_q, tick_d_q, presc_q;
  logic [FW-1:0]    a_sec_q, a_min_q, a_hour_q;
  logic [DAY_W-1:0] a_day_q;
  logic             tick_ok;

  // a time load discards a coincident tick for the whole chain
  assign tick_ok = en_q && tick_i && !time_wr;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      tick_d_q <= 1'b0;
      presc_q  <= 1'b0;
      a_sec_q  <= '0;
      a_min_q  <= '0;
      a_hour_q <= '0;
      a_day_q  <= '0;
    end else begin
      tick_d_q <= tick_ok;
      presc_q  <= time_wr;
      if (wr_ctrl) en_q <= bus_wdata_i[BIT_RUN];
      if (wr_asec) a_sec_q <= bus_wdata_i[FW-1:0];
      if (wr_ahm) begin
        a_min_q  <= bus_wdata_i[FW-1:0];
        a_hour_q <= bus_wdata_i[DATA_W-1:FW];
      end
      if (wr_aday) a_day_q <= bus_wdata_i[DAY_W-1:0];
    end
  end

  assign presc_clear_o = presc_q;

  // ---------------- counter chain ----------------
  logic [FW-1:0]    sec_q, min_q, hour_q;
  logic [DAY_W-1:0] day_q;
  logic             sec_wrap, min_wrap, hour_wrap, day_wrap;

  rtc_mod_counter #(.W(FW), .MAX(SEC_LAST)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(tick_ok), .ld_i(wr_sec),
    .ld_val_i(bus_wdata_i[FW-1:0]), .cnt_o(sec_q), .wrap_o(sec_wrap));

  rtc_mod_counter #(.W(FW), .MAX(MIN_LAST)) u_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_wrap), .ld_i(wr_hm),
    .ld_val_i(bus_wdata_i[FW-1:0]), .cnt_o(min_q), .wrap_o(min_wrap));

  rtc_mod_counter #(.W(FW), .MAX(HOUR_LAST)) u_hour (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_wrap), .ld_i(wr_hm),
    .ld_val_i(bus_wdata_i[DATA_W-1:FW]), .cnt_o(hour_q), .wrap_o(hour_wrap));

  rtc_mod_counter #(.W(DAY_W), .MAX(DAY_LAST)) u_day (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hour_wrap), .ld_i(wr_day),
    .ld_val_i(bus_wdata_i[DAY_W-1:0]), .cnt_o(day_q), .wrap_o(day_wrap));

  // ---------------- events ----------------
  logic alarm_hit;

  rtc_alarm_match #(.FW(FW), .DAY_W(DAY_W)) u_match (
    .sec_i(sec_q), .min_i(min_q), .hour_i(hour_q), .day_i(day_q),
    .a_sec_i(a_sec_q), .a_min_i(a_min_q), .a_hour_i(a_hour_q), .a_day_i(a_day_q),
    .hit_o(alarm_hit));

  logic [DATA_W-1:0] status_w, ien_w;

  // counters hold post-tick values while tick_d_q is high
  rtc_irq_flags #(.DATA_W(DATA_W), .A_BIT(BIT_ALARM), .S_BIT(BIT_SECOND)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_alarm_i(tick_d_q && alarm_hit), .set_second_i(tick_d_q),
    .stat_wr_i(wr_stat), .ien_wr_i(wr_ien), .wdata_i(bus_wdata_i),
    .status_o(status_w), .ien_o(ien_w), .irq_o(irq_o));

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata_o = '0;
    unique case (int'(bus_addr_i))
      OFF_HM:   bus_rdata_o = {hour_q, min_q};
      OFF_SEC:  bus_rdata_o = DATA_W'(sec_q);
      OFF_AHM:  bus_rdata_o = {a_hour_q, a_min_q};
      OFF_ASEC: bus_rdata_o = DATA_W'(a_sec_q);
      OFF_CTRL: bus_rdata_o[BIT_RUN] = en_q;
      OFF_STAT: bus_rdata_o = status_w;
      OFF_IEN:  bus_rdata_o = ien_w;
      OFF_DAY:  bus_rdata_o = DATA_W'(day_q);
      OFF_ADAY: bus_rdata_o = DATA_W'(a_day_q);
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk
  import rtc_pkg::*;
#(
  parameter int FW     = 8,
  parameter int DAY_W  = 9,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_i,
  input logic              time_wr_i,
  input logic              tick_d_i,
  input logic              sec_wr_i,
  input logic              stat_wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [FW-1:0]     sec_i,
  input logic [FW-1:0]     min_i,
  input logic [FW-1:0]     hour_i,
  input logic [DAY_W-1:0]  day_i,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] ien_i,
  input logic              irq_i,
  input logic              presc_i
);
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !time_wr_i && sec_i < FW'(SEC_LAST)) |=> sec_i == $past(sec_i) + FW'(1)); // R4
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !time_wr_i && sec_i >= FW'(SEC_LAST)) |=> (sec_i == '0 && min_i != $past(min_i))); // R4
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !time_wr_i) |=> ($stable(sec_i) && $stable(min_i) && $stable(hour_i) && $stable(day_i))); // R3
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr_i |=> sec_i == $past(wdata_i[FW-1:0])); // R10
  AST_PRESC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_i |-> $past(time_wr_i)); // R10
  AST_CLEAR_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && wdata_i[BIT_SECOND] && !tick_d_i) |=> !status_i[BIT_SECOND]); // R8
  AST_ALARM_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[BIT_ALARM]) |-> $past(tick_d_i)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |-> !irq_i); // R9
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.FW(FW), .DAY_W(DAY_W), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .tick_i(tick_i), .time_wr_i(time_wr),
  .tick_d_i(tick_d_q), .sec_wr_i(wr_sec), .stat_wr_i(wr_stat), .wdata_i(bus_wdata_i),
  .sec_i(sec_q), .min_i(min_q), .hour_i(hour_q), .day_i(day_q),
  .status_i(status_w), .ien_i(ien_w), .irq_i(irq_o), .presc_i(presc_clear_o));

// File: tb/rtc_timekeeper_tb_top.sv
`timescale 1ns/1ps
module rtc_timekeeper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, presc;

  always #2.5 clk = ~clk;

  rtc_timekeeper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .presc_clear_o(presc));

  localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08, A_ASEC = 6'h0C,
                         A_CTRL = 6'h10, A_STAT = 6'h14, A_IEN = 6'h18,
                         A_DAY = 6'h20, A_ADAY = 6'h24;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 prescaler clear
    logic [15:0] exp;
    string       name;
  } item_t;

  item_t sb_q[$];
  logic  probe_v = 1'b0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // monitor: pops one expectation per probed cycle, samples mid-cycle
  always @(negedge clk) begin
    if (probe_v && sb_q.size() > 0) begin
      item_t       it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {15'b0, irq};
        default: act = {15'b0, presc};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s act=%h exp=%h", it.name, act, it.exp);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic step();
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0; probe_v = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    step(); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr_tick(input logic [5:0] a, input logic [15:0] d);
    step(); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
  endtask

  task automatic tick_pulse();
    step(); tick = 1'b1;
    step();
  endtask

  // tick, then clear all flags in the very cycle the second flag sets
  task automatic tick_then_clear();
    step(); tick = 1'b1;
    step(); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 16'hFFFF;
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [15:0] e, input string nm);
    step(); bus_sel = 1'b1; bus_addr = a; probe_v = 1'b1;
    sb_q.push_back('{0, e, nm});
  endtask

  task automatic chk_irq(input logic e, input string nm);
    step(); probe_v = 1'b1;
    sb_q.push_back('{1, {15'b0, e}, nm});
  endtask

  task automatic chk_presc(input logic e, input string nm);
    step(); probe_v = 1'b1;
    sb_q.push_back('{2, {15'b0, e}, nm});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_rd(A_CTRL, 16'h0000, "R1 ctrl after reset");
    chk_rd(A_HM,   16'h0000, "R1 hm after reset");
    chk_rd(A_DAY,  16'h0000, "R1 day after reset");
    chk_rd(A_STAT, 16'h0000, "R1 status after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R3 enable bit, readback, hold while off
    wr(A_CTRL, 16'hFFFF);
    chk_rd(A_CTRL, 16'h0080, "R3 ctrl keeps only bit 7");
    wr(A_CTRL, 16'h0000);
    tick_pulse();
    chk_rd(A_SEC,  16'h0000, "R3 seconds hold while off");
    chk_rd(A_STAT, 16'h0000, "R3 no flag while off");
    wr(A_CTRL, 16'h0080);

    // R10 load and prescaler restart, R4 single step
    wr(A_SEC, 16'h0005);
    chk_presc(1'b1, "R10 prescaler clear pulse");
    chk_presc(1'b0, "R10 prescaler clear one cycle");
    tick_pulse();
    chk_rd(A_SEC, 16'h0006, "R4 seconds step");

    // R4 full day rollover; R2 packing
    wr(A_DAY, 16'h0003);
    wr(A_HM, 16'h173B);
    chk_rd(A_HM, 16'h173B, "R2 hour high byte minute low byte");
    wr(A_SEC, 16'h003B);
    tick_pulse();
    chk_rd(A_SEC, 16'h0000, "R4 seconds wrap");
    chk_rd(A_HM,  16'h0000, "R4 hour and minute wrap");
    chk_rd(A_DAY, 16'h0004, "R4 day carry");

    // R6 second flag, R8 write-one-to-clear
    chk_rd(A_STAT, 16'h0010, "R6 second flag set");
    wr(A_STAT, 16'h0000);
    chk_rd(A_STAT, 16'h0010, "R8 zero write keeps flag");
    wr(A_STAT, 16'h0010);
    chk_rd(A_STAT, 16'h0000, "R8 one write clears flag");

    // R9 interrupt masking
    wr(A_IEN, 16'hFFFF);
    chk_rd(A_IEN, 16'h0014, "R9 enable keeps bits 2 and 4");
    wr(A_IEN, 16'h0010);
    tick_pulse();
    chk_irq(1'b1, "R9 irq on enabled second flag");
    wr(A_STAT, 16'hFFFF);
    chk_irq(1'b0, "R9 irq drops after clear");

    // R7 alarm
    wr(A_ADAY, 16'h0004);
    wr(A_AHM,  16'h0001);
    wr(A_ASEC, 16'h0005);
    chk_rd(A_AHM,  16'h0001, "R2 alarm hm readback");
    chk_rd(A_ADAY, 16'h0004, "R2 alarm day readback");
    chk_rd(6'h1C,  16'h0000, "R2 unmapped reads zero");
    wr(A_HM, 16'h0001);
    wr(A_SEC, 16'h0003);
    wr(A_IEN, 16'h0004);
    tick_pulse();
    chk_rd(A_STAT, 16'h0010, "R7 no alarm before match");
    chk_irq(1'b0, "R9 second flag masked");
    tick_pulse();
    chk_rd(A_STAT, 16'h0014, "R7 alarm on matching tick");
    chk_irq(1'b1, "R9 irq on alarm");
    wr(A_STAT, 16'hFFFF);
    tick_pulse();
    chk_rd(A_STAT, 16'h0010, "R7 alarm fires once");
    wr(A_STAT, 16'hFFFF);
    wr(A_SEC, 16'h0005);
    step();
    chk_rd(A_STAT, 16'h0000, "R7 write match sets no alarm");

    // R4 overrange field
    wr(A_SEC, 16'h003F);
    tick_pulse();
    chk_rd(A_SEC, 16'h0000, "R4 overrange seconds wrap");
    chk_rd(A_HM,  16'h0002, "R4 overrange carries minute");

    // R5 day wrap
    wr(A_DAY, 16'h01FF);
    wr(A_HM, 16'h173B);
    wr(A_SEC, 16'h003B);
    tick_pulse();
    chk_rd(A_DAY, 16'h0000, "R5 day wraps 511 to 0");

    // R10 write beats tick
    wr(A_STAT, 16'hFFFF);
    wr_tick(A_SEC, 16'h000A);
    step();
    chk_rd(A_SEC,  16'h000A, "R10 write wins over tick");
    chk_rd(A_STAT, 16'h0000, "R10 discarded tick sets no flag");

    // R8 set outranks clear
    tick_then_clear();
    chk_rd(A_STAT, 16'h0010, "R8 set wins over clear");

    step();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule